// File: doc/BRIEF.md
# PC Card Memory Cycle Timer

This block runs one 16-bit memory read or write on a PC Card socket. A host presents a request made of an address, write data, a read/write flag, a register-space flag, a byte-access flag and a timer-set number. The block then steps through three phases. In the setup phase the address, space select, card enables and write data are driven. In the command phase the read or write strobe is asserted. In the recovery phase the strobe is released while the address and data stay driven. For a read, the card's data is captured at the moment the read strobe is released. A done pulse follows the last recovery clock.

Each phase length is one clock more than a programmable 8-bit value. Two timer sets each hold a setup, a command and a recovery value, and these are written and read back through a small configuration port. The card can stretch the command phase with its active-low wait line. That line passes through a two-flop synchronizer. The strobe is held for as long as the synchronized wait is active, and for exactly two clocks after it is seen released.

Top module: `pcmem_cycle_timer`

## Requirements
- R1: After reset, req_ready is 1, done is 0, card_ce_n is 2'b11, card_oe_n, card_we_n and card_reg_n are 1, card_dout_en is 0 and rd_data is 0. Both timer sets read back setup 8'h00, command 8'h07 and recovery 8'h04.
- R2: cfg_addr selects the timer register. Bit 2 is the set and bits 1:0 are the field: 0 for setup, 1 for command, 2 for recovery. Field 3 reads as 0. A write with cfg_we high lands at the next clock edge, and cfg_rdata shows the addressed value combinationally.
- R3: A request accepted in the idle state starts a setup phase of S = setup+1 clocks on the next clock. During setup the card enables and card_reg_n are active and card_addr is driven, while both strobes stay high.
- R4: The command phase follows setup. For a read it drives card_oe_n low and for a write it drives card_we_n low, for C = command+1 clocks when no wait occurs. The other strobe stays high, and the two strobes are never low together.
- R5: The recovery phase lasts R = recovery+1 clocks with both strobes high. The card enables, card_addr and (for writes) card_dout stay unchanged.
- R6: req_set, sampled with the request, chooses which timer set times the cycle.
- R7: card_wait_n is synchronized through two flops. If the synchronized wait is active on the last command clock, the strobe stays low while it remains active. After the synchronized wait is seen inactive, the strobe stays low for exactly 2 more clocks.
- R8: A wait that the synchronizer has not yet passed on by the last command clock does not lengthen the strobe. A wait during setup-free idle, recovery or idle has no effect.
- R9: For a read, rd_data takes card_din at the clock edge that releases card_oe_n. It keeps that value until the next read captures data, so writes leave it unchanged.
- R10: A 16-bit access (req_byte 0) drives card_ce_n to 2'b00. A byte access drives 2'b10, so only bit 0 is low. card_reg_n is low for the whole cycle when req_reg is 1.
- R11: req_ready is 1 only in the idle state, and a request while busy is ignored. done is high for one clock, in the clock after the last recovery clock, and req_ready returns in the clock after done.
- R12: card_dout_en is 1 from setup through recovery of a write only, and during that time card_dout equals the request's write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Timer register write enable |
| cfg_addr | input | 3 | Timer register address {set, field} |
| cfg_wdata | input | 8 | Timer register write value |
| cfg_rdata | output | 8 | Addressed timer register value |
| req_valid | input | 1 | Cycle request, taken when req_ready is 1 |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_reg | input | 1 | 1 selects the register space |
| req_byte | input | 1 | 1 for a byte access on the low enable only |
| req_set | input | 1 | Timer set to use |
| req_addr | input | 26 | Card address |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Captured read data |
| card_ce_n | output | 2 | Active-low card enables, bit 0 for the low byte |
| card_reg_n | output | 1 | Active-low register-space select |
| card_oe_n | output | 1 | Active-low read strobe |
| card_we_n | output | 1 | Active-low write strobe |
| card_addr | output | 26 | Address to the card |
| card_dout | output | 16 | Write data to the card |
| card_dout_en | output | 1 | Data output enable for writes |
| card_din | input | 16 | Data from the card |
| card_wait_n | input | 1 | Active-low wait from the card, asynchronous |

## Verification
The assertions assume that the timer registers are written only while req_ready is 1. Because the timing is latched when a request is taken, this also keeps the address-stability and strobe-ordering properties meaningful. They also assume that reset is held for at least one clock before the first request. The stimulus obeys both assumptions: every configuration write is made between cycles, after done has been seen. Wait pulses are timed from the observed fall of the strobe, so that the cases inside the window, late in the window and in recovery are each reached on purpose.

// File: rtl/pcmem_pkg.sv
package pcmem_pkg;

    localparam int PCM_CNT_W   = 8;
    localparam int PCM_FIELD_W = 2;

    localparam logic [PCM_FIELD_W-1:0] FLD_SETUP = 2'd0;
    localparam logic [PCM_FIELD_W-1:0] FLD_CMD   = 2'd1;
    localparam logic [PCM_FIELD_W-1:0] FLD_RECOV = 2'd2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_CMD,
        PH_STRETCH,
        PH_TAIL,
        PH_RECOV,
        PH_DONE
    } phase_t;

    typedef struct packed {
        logic [PCM_CNT_W-1:0] setup;
        logic [PCM_CNT_W-1:0] cmd;
        logic [PCM_CNT_W-1:0] recov;
    } timing_t;

    function automatic timing_t reset_timing();
        timing_t t;
        t.setup = 8'h00;
        t.cmd   = 8'h07;
        t.recov = 8'h04;
        return t;
    endfunction

    function automatic logic [PCM_CNT_W-1:0] field_value(timing_t t,
                                                         logic [PCM_FIELD_W-1:0] f);
        case (f)
            FLD_SETUP: return t.setup;
            FLD_CMD:   return t.cmd;
            FLD_RECOV: return t.recov;
            default:   return '0;
        endcase
    endfunction

    function automatic timing_t field_update(timing_t t,
                                             logic [PCM_FIELD_W-1:0] f,
                                             logic [PCM_CNT_W-1:0] v);
        timing_t n;
        n = t;
        case (f)
            FLD_SETUP: n.setup = v;
            FLD_CMD:   n.cmd   = v;
            FLD_RECOV: n.recov = v;
            default:   n = t;
        endcase
        return n;
    endfunction

    function automatic logic [1:0] enable_pattern(logic byte_acc);
        return byte_acc ? 2'b10 : 2'b00;
    endfunction

    function automatic logic phase_active(phase_t p);
        return (p == PH_SETUP) || (p == PH_CMD) || (p == PH_STRETCH) ||
               (p == PH_TAIL)  || (p == PH_RECOV);
    endfunction

    function automatic logic phase_strobe(phase_t p);
        return (p == PH_CMD) || (p == PH_STRETCH) || (p == PH_TAIL);
    endfunction

endpackage

// File: rtl/pcmem_timer_regs.sv
module pcmem_timer_regs
    import pcmem_pkg::*;
#(
    parameter int NSETS = 2,
    parameter int SET_W = 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_we,
    input  logic [SET_W+PCM_FIELD_W-1:0]  cfg_addr,
    input  logic [PCM_CNT_W-1:0]          cfg_wdata,
    output logic [PCM_CNT_W-1:0]          cfg_rdata,
    input  logic [SET_W-1:0]              sel_set,
    output timing_t                       sel_timing
);

    timing_t bank [NSETS];

    logic [SET_W-1:0]       wr_set;
    logic [PCM_FIELD_W-1:0] wr_field;

    assign wr_set   = cfg_addr[SET_W+PCM_FIELD_W-1:PCM_FIELD_W];
    assign wr_field = cfg_addr[PCM_FIELD_W-1:0];

    for (genvar g = 0; g < NSETS; g++) begin : g_set
        always_ff @(posedge clk) begin
            if (rst) begin
                bank[g] <= reset_timing();
            end else if (cfg_we && (wr_set == SET_W'(g))) begin
                bank[g] <= field_update(bank[g], wr_field, cfg_wdata);
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NSETS; i++) begin
            if (wr_set == SET_W'(i)) cfg_rdata = field_value(bank[i], wr_field);
        end
    end

    always_comb begin
        sel_timing = bank[0];
        for (int i = 0; i < NSETS; i++) begin
            if (sel_set == SET_W'(i)) sel_timing = bank[i];
        end
    end

endmodule

// File: rtl/pcmem_wait_sync.sv
module pcmem_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic wait_n_async,
    output logic wait_active
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], ~wait_n_async};
    end

    assign wait_active = chain[STAGES-1];

endmodule

// File: rtl/pcmem_seq.sv
module pcmem_seq
    import pcmem_pkg::*;
#(
    parameter int ADDR_W      = 26,
    parameter int DATA_W      = 16,
    parameter int TAIL_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_reg,
    input  logic              req_byte,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  timing_t           sel_timing,
    input  logic              wait_active,
    input  logic [DATA_W-1:0] card_din,
    output phase_t            phase,
    output logic              lat_write,
    output logic              lat_reg,
    output logic              lat_byte,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [DATA_W-1:0] lat_wdata,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic [PCM_CNT_W-1:0] TAIL_LOAD = PCM_CNT_W'(TAIL_CYCLES - 1);

    timing_t              tim_q;
    logic [PCM_CNT_W-1:0] cnt;
    logic                 cnt_zero;

    assign cnt_zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            tim_q     <= '0;
            lat_write <= 1'b0;
            lat_reg   <= 1'b0;
            lat_byte  <= 1'b0;
            lat_addr  <= '0;
            lat_wdata <= '0;
            rd_data   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        lat_write <= req_write;
                        lat_reg   <= req_reg;
                        lat_byte  <= req_byte;
                        lat_addr  <= req_addr;
                        lat_wdata <= req_wdata;
                        tim_q     <= sel_timing;
                        cnt       <= sel_timing.setup;
                        phase     <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (cnt_zero) begin
                        cnt   <= tim_q.cmd;
                        phase <= PH_CMD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_CMD: begin
                    if (!cnt_zero) begin
                        cnt <= cnt - 1'b1;
                    end else if (wait_active) begin
                        phase <= PH_STRETCH;
                    end else begin
                        cnt   <= tim_q.recov;
                        phase <= PH_RECOV;
                        if (!lat_write) rd_data <= card_din;
                    end
                end
                PH_STRETCH: begin
                    if (!wait_active) begin
                        cnt   <= TAIL_LOAD;
                        phase <= PH_TAIL;
                    end
                end
                PH_TAIL: begin
                    if (cnt_zero) begin
                        cnt   <= tim_q.recov;
                        phase <= PH_RECOV;
                        if (!lat_write) rd_data <= card_din;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_RECOV: begin
                    if (cnt_zero) phase <= PH_DONE;
                    else          cnt   <= cnt - 1'b1;
                end
                PH_DONE: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pcmem_cycle_timer.sv
module pcmem_cycle_timer
    import pcmem_pkg::*;
#(
    parameter int ADDR_W      = 26,
    parameter int DATA_W      = 16,
    parameter int NSETS       = 2,
    parameter int SYNC_STAGES = 2,
    parameter int TAIL_CYCLES = 2,
    localparam int SET_W      = (NSETS > 1) ? $clog2(NSETS) : 1,
    localparam int CFG_AW     = SET_W + PCM_FIELD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_reg,
    input  logic              req_byte,
    input  logic [SET_W-1:0]  req_set,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        card_ce_n,
    output logic              card_reg_n,
    output logic              card_oe_n,
    output logic              card_we_n,
    output logic [ADDR_W-1:0] card_addr,
    output logic [DATA_W-1:0] card_dout,
    output logic              card_dout_en,
    input  logic [DATA_W-1:0] card_din,
    input  logic              card_wait_n
);

    timing_t           sel_timing;
    logic              wait_active;
    phase_t            phase;
    logic              lat_write;
    logic              lat_reg;
    logic              lat_byte;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wdata;
    logic              active;
    logic              strobe;

    pcmem_timer_regs #(
        .NSETS (NSETS),
        .SET_W (SET_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .sel_set    (req_set),
        .sel_timing (sel_timing)
    );

    pcmem_wait_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk          (clk),
        .rst          (rst),
        .wait_n_async (card_wait_n),
        .wait_active  (wait_active)
    );

    pcmem_seq #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .TAIL_CYCLES (TAIL_CYCLES)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_reg     (req_reg),
        .req_byte    (req_byte),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .sel_timing  (sel_timing),
        .wait_active (wait_active),
        .card_din    (card_din),
        .phase       (phase),
        .lat_write   (lat_write),
        .lat_reg     (lat_reg),
        .lat_byte    (lat_byte),
        .lat_addr    (lat_addr),
        .lat_wdata   (lat_wdata),
        .rd_data     (rd_data)
    );

    assign active       = phase_active(phase);
    assign strobe       = phase_strobe(phase);
    assign req_ready    = (phase == PH_IDLE);
    assign done         = (phase == PH_DONE);
    assign card_ce_n    = active ? enable_pattern(lat_byte) : 2'b11;
    assign card_reg_n   = !(active && lat_reg);
    assign card_oe_n    = !(strobe && !lat_write);
    assign card_we_n    = !(strobe && lat_write);
    assign card_addr    = lat_addr;
    assign card_dout    = lat_wdata;
    assign card_dout_en = active && lat_write;

endmodule

// File: rtl/pcmem_cycle_timer_chk.sv
module pcmem_cycle_timer_chk #(
    parameter int ADDR_W = 26
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        card_ce_n,
    input logic              card_oe_n,
    input logic              card_we_n,
    input logic [ADDR_W-1:0] card_addr,
    input logic              done,
    input logic              req_ready
);

    assert_strobes_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(!card_oe_n && !card_we_n));

    assert_strobe_under_enable_R10: assert property (@(posedge clk) disable iff (rst)
        (!card_oe_n || !card_we_n) |-> !card_ce_n[0]);

    assert_setup_precedes_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        ($fell(card_oe_n) || $fell(card_we_n)) |-> $past(!card_ce_n[0] && card_oe_n && card_we_n));

    assert_addr_held_R5: assert property (@(posedge clk) disable iff (rst)
        (!card_ce_n[0] && $past(!card_ce_n[0])) |-> $stable(card_addr));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_ready_after_done_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> req_ready);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (card_ce_n == 2'b11 && card_oe_n && card_we_n));

endmodule

bind pcmem_cycle_timer pcmem_cycle_timer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .card_ce_n (card_ce_n),
    .card_oe_n (card_oe_n),
    .card_we_n (card_we_n),
    .card_addr (card_addr),
    .done      (done),
    .req_ready (req_ready)
);

// File: tb/pcmem_cycle_timer_bench.sv
`timescale 1ns/1ps
module pcmem_cycle_timer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_reg = 1'b0;
    logic        req_byte = 1'b0;
    logic        req_set = 1'b0;
    logic [25:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        done;
    logic [15:0] rd_data;
    logic [1:0]  card_ce_n;
    logic        card_reg_n;
    logic        card_oe_n;
    logic        card_we_n;
    logic [25:0] card_addr;
    logic [15:0] card_dout;
    logic        card_dout_en;
    logic [15:0] card_din = '0;
    logic        card_wait_n = 1'b1;

    always #2 clk = ~clk;

    pcmem_cycle_timer u_pcmem_cycle_timer (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_reg(req_reg), .req_byte(req_byte), .req_set(req_set),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .done(done), .rd_data(rd_data),
        .card_ce_n(card_ce_n), .card_reg_n(card_reg_n), .card_oe_n(card_oe_n),
        .card_we_n(card_we_n), .card_addr(card_addr), .card_dout(card_dout),
        .card_dout_en(card_dout_en), .card_din(card_din), .card_wait_n(card_wait_n)
    );

    int checks = 0;
    int fails  = 0;
    bit summary_done = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
        end
    endtask

    // Behavioural reference: phase 0 idle, 1 setup, 2 command, 3 held by wait,
    // 4 two-clock tail, 5 recovery, 6 done.
    int mirror [2][3];
    int m_ph = 0;
    int m_el = 0;
    int m_S, m_C, m_R;
    bit m_wr, m_reg, m_byte;
    logic [25:0] m_addr;
    logic [15:0] m_wdata;
    logic [15:0] m_rd = '0;
    bit sync1 = 0, sync2 = 0;
    int cur_len = 0, last_len = 0;

    initial begin
        for (int s = 0; s < 2; s++) begin
            mirror[s][0] = 0; mirror[s][1] = 7; mirror[s][2] = 4;
        end
    end

    always @(posedge clk) begin
        bit wa;
        if (rst) begin
            m_ph = 0; m_el = 0; m_rd = '0; sync1 = 0; sync2 = 0;
        end else begin
            wa = sync2;
            sync2 = sync1;
            sync1 = !card_wait_n;
            case (m_ph)
                0: if (req_valid) begin
                    m_wr = req_write; m_reg = req_reg; m_byte = req_byte;
                    m_addr = req_addr; m_wdata = req_wdata;
                    m_S = mirror[req_set][0] + 1;
                    m_C = mirror[req_set][1] + 1;
                    m_R = mirror[req_set][2] + 1;
                    m_ph = 1; m_el = 0;
                end
                1: begin m_el++; if (m_el == m_S) begin m_ph = 2; m_el = 0; end end
                2: begin
                    m_el++;
                    if (m_el == m_C) begin
                        if (wa) m_ph = 3;
                        else begin m_ph = 5; m_el = 0; if (!m_wr) m_rd = card_din; end
                    end
                end
                3: if (!wa) begin m_ph = 4; m_el = 0; end
                4: begin
                    m_el++;
                    if (m_el == 2) begin m_ph = 5; m_el = 0; if (!m_wr) m_rd = card_din; end
                end
                5: begin m_el++; if (m_el == m_R) m_ph = 6; end
                default: m_ph = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        bit act, stb;
        string stag;
        if (!rst) begin
            act = (m_ph >= 1 && m_ph <= 5);
            stb = (m_ph >= 2 && m_ph <= 4);
            stag = (m_ph == 1) ? "R3" : (m_ph == 5) ? "R5" : (m_ph >= 3 && m_ph <= 4) ? "R7" : "R4";
            chk({stag, " read strobe"},  card_oe_n, !(stb && !m_wr));
            chk({stag, " write strobe"}, card_we_n, !(stb && m_wr));
            chk("R10 card enables", card_ce_n, act ? (m_byte ? 2'b10 : 2'b00) : 2'b11);
            chk("R10 register select", card_reg_n, !(act && m_reg));
            chk("R11 ready", req_ready, m_ph == 0);
            chk("R11 done", done, m_ph == 6);
            chk("R12 data enable", card_dout_en, act && m_wr);
            chk("R9 read data", rd_data, m_rd);
            if (act) chk({stag, " address"}, card_addr, m_addr);
            if (act && m_wr) chk("R12 write data", card_dout, m_wdata);
            if (!card_oe_n || !card_we_n) cur_len++;
            else if (cur_len != 0) begin last_len = cur_len; cur_len = 0; end
        end
    end

    task automatic cfg_write(int set, int field, int val);
        @(negedge clk);
        cfg_we = 1; cfg_addr = 3'(set * 4 + field); cfg_wdata = 8'(val);
        @(negedge clk);
        cfg_we = 0;
        mirror[set][field] = val;
    endtask

    task automatic cfg_check(string tag, int set, int field, int exp);
        cfg_addr = 3'(set * 4 + field);
        #1;
        chk(tag, cfg_rdata, 32'(exp));
    endtask

    task automatic run_cycle(bit wr, bit rg, bit by, bit st, logic [25:0] a,
                             logic [15:0] wd, logic [15:0] din);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_reg = rg; req_byte = by; req_set = st;
        req_addr = a; req_wdata = wd; card_din = din;
        @(negedge clk);
        req_valid = 0;
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wait_pulse(int delay, int len);
        do @(negedge clk); while (card_oe_n && card_we_n);
        repeat (delay) @(negedge clk);
        card_wait_n = 0;
        repeat (len) @(negedge clk);
        card_wait_n = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset values of both timer sets
        for (int s = 0; s < 2; s++) begin
            cfg_check("R1 reset setup", s, 0, 8'h00);
            cfg_check("R1 reset command", s, 1, 8'h07);
            cfg_check("R1 reset recovery", s, 2, 8'h04);
        end
        // R1/R4/R5/R3: default read, 16-bit, set 0: strobe of 8 clocks
        run_cycle(0, 0, 0, 0, 26'h123_4567, 16'h0, 16'hBEEF);
        chk("R4 strobe length set0", last_len, 8);
        chk("R9 captured data", rd_data, 16'hBEEF);
        // R2: program set 1 and read back
        cfg_write(1, 0, 2);
        cfg_write(1, 1, 3);
        cfg_write(1, 2, 1);
        cfg_check("R2 set1 setup", 1, 0, 2);
        cfg_check("R2 set1 command", 1, 1, 3);
        cfg_check("R2 set1 recovery", 1, 2, 1);
        cfg_check("R2 unused field", 1, 3, 0);
        cfg_check("R2 set0 untouched", 0, 1, 7);
        // R6/R10/R12: byte write with set 1, register space
        run_cycle(1, 1, 1, 1, 26'h2AA_AAAA, 16'h5A5A, 16'h1111);
        chk("R6 strobe length set1", last_len, 4);
        chk("R9 write leaves read data", rd_data, 16'hBEEF);
        // R7: wait from the first strobe clock for 10 clocks -> 15 strobe clocks
        fork
            run_cycle(0, 0, 0, 0, 26'h000_0F0F, 16'h0, 16'hC0DE);
            wait_pulse(0, 10);
        join
        chk("R7 stretched strobe length", last_len, 15);
        chk("R9 data after stretch", rd_data, 16'hC0DE);
        // R8: wait appearing on strobe clock 3 of C=4 is too late
        fork
            run_cycle(1, 0, 0, 1, 26'h3FF_FFFF, 16'hA5A5, 16'h0);
            wait_pulse(2, 3);
        join
        chk("R8 late wait ignored", last_len, 4);
        // R8: wait during recovery of a C=4 cycle has no effect
        fork
            run_cycle(0, 1, 1, 1, 26'h001_0203, 16'h0, 16'h7E7E);
            wait_pulse(4, 2);
        join
        chk("R8 recovery wait ignored", last_len, 4);
        // R11: request while busy is ignored
        fork
            run_cycle(0, 0, 0, 0, 26'h0AB_CDEF, 16'h0, 16'h4242);
            begin
                repeat (4) @(negedge clk);
                req_valid = 1; req_addr = 26'h111_1111; req_write = 1;
                @(negedge clk);
                req_valid = 0; req_write = 0;
            end
        join
        chk("R11 busy request dropped", req_ready, 1);
        repeat (3) @(negedge clk);
        chk("R11 still idle", req_ready, 1);
        // Boundary: all set 0 values zero -> one clock each phase
        cfg_write(0, 0, 0);
        cfg_write(0, 1, 0);
        cfg_write(0, 2, 0);
        run_cycle(0, 0, 0, 0, 26'h155_5555, 16'h0, 16'h0F0F);
        chk("R4 minimum strobe", last_len, 1);
        chk("R9 minimum read data", rd_data, 16'h0F0F);
        run_cycle(1, 0, 0, 0, 26'h0C3_0C30, 16'h9999, 16'h0);
        chk("R12 minimum write strobe", last_len, 1);
        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

endmodule